// File: doc/BRIEF.md
# Keyed windowed watchdog timer

This block is a supervision timer that runs from the 32768 Hz slow clock of a chip. A prescaler turns that clock into a 256 Hz tick, and the tick decrements a 12-bit down-counter. Software has to restart the counter before it runs out. A timeout of N seconds (1 to 16) is programmed as a load value of N*256-1. If the counter runs past zero, the block raises a reset request, an interrupt request, or both, depending on the mode. A restart is honoured only when the written word carries a password. The restart must also fall inside a window: a restart that comes while the counter is still above the window value counts as a fault.

Software reaches the block through a single-cycle register write port and a combinational read port. There are four word addresses: control (write only), mode (read and write), status (read, cleared by the read) and the live counter value (read only). Two inputs, one for the idle state and one for the debug state, can freeze the count when the mode allows it.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the mode word reads 0x0FFF2FFF: enabled, load and window both 0xFFF, reset-enable set, everything else clear. The counter reads 0xFFF, the status reads 0, and both requests are low.
- R2: Mode word layout: load value in bits [11:0], interrupt-enable in bit 12, reset-enable in bit 13, idle-halt in bit 14, debug-halt in bit 15, window in bits [27:16], disable in bit 31. While enabled and not halted, the counter steps down once per DIV clocks. The step that finds it at zero is an underflow, and that step puts the load value back in the counter. The first underflow comes DIV*(L+1) clocks after a load.
- R3: On an underflow the status reads bit 0 set. If reset-enable is set, reset_req is high for exactly the one clock after the underflow edge. If reset-enable is clear, reset_req stays low.
- R4: A write to address 0 restarts the counter (load value back in, prescaler cleared) only when bits [31:24] equal 0xA5 and bit 0 is 1. Any other control word has no effect on the counter.
- R5: A keyed restart that arrives while enabled and while the counter is above the window field is refused. The counter keeps its value, status bit 1 is set, and a fault is raised in the same way as for an underflow. A restart with the counter at or below the window is accepted.
- R6: For the three clocks after an accepted restart, writes to address 0 and address 1 are ignored. The fourth write is accepted.
- R7: A mode write that keeps the disable bit set leaves the load and window fields unchanged, while the other fields still take the written value. A write that clears the disable bit changes them. While disabled, the counter does not move and no underflow occurs.
- R8: Every accepted mode write loads the counter with the new load value.
- R9: With idle-halt set, the count and the prescaler freeze while idle is high. Debug-halt does the same for debug. A halt input has no effect when its enable bit is clear.
- R10: Reading address 2 returns {win_err, underflow} in bits [1:0] and clears both bits. irq_req equals interrupt-enable AND (either status bit), so it holds until that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 mode |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (side effect: clears status on address 2) |
| rd_addr | input | 2 | Read address: 1 mode, 2 status, 3 counter |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| idle | input | 1 | System idle indication |
| debug | input | 1 | Debugger halt indication |
| reset_req | output | 1 | One-clock reset request on a fault |
| irq_req | output | 1 | Level interrupt request until status is read |

## Verification
The bench sweeps small load values to catch an off-by-one in the underflow point, which would show up as a fault one tick early or late. It also checks that the counter comes back at the load value after an underflow. It restarts the counter too early and then in time, to catch a window comparison that uses the wrong sense or the wrong bound. It also checks that a refused restart leaves the counter alone rather than quietly reloading it. Mode writes issued on each of the three clocks after a restart expose a lock that is one cycle short or one cycle long. Disabled-mode writes show whether the load and window freeze is missing, and toggling each halt input with its enable on and off shows whether a halt is ignored or applied without being enabled.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int STAT_W = 2;
    localparam logic [7:0] RESTART_KEY = 8'hA5;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_MODE = 2'd1,
        A_STAT = 2'd2,
        A_CNT  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       dis;
        logic [2:0] rsv;
        cnt_t       window;
        logic       dbg_halt;
        logic       idle_halt;
        logic       rst_en;
        logic       irq_en;
        cnt_t       reload;
    } mode_t;

    typedef struct packed {
        logic win_err;
        logic underflow;
    } status_t;

    function automatic mode_t mode_reset();
        mode_t m;
        m           = '0;
        m.reload    = CNT_MAX;
        m.window    = CNT_MAX;
        m.rst_en    = 1'b1;
        return m;
    endfunction

    function automatic logic is_restart(logic [DATA_W-1:0] w);
        return (w[DATA_W-1 -: 8] == RESTART_KEY) && w[0];
    endfunction

    // The timing fields stay frozen unless the write also leaves the disabled state.
    function automatic mode_t mode_merge(mode_t cur, mode_t req);
        mode_t m;
        m     = req;
        m.rsv = '0;
        if (cur.dis && req.dis) begin
            m.reload = cur.reload;
            m.window = cur.window;
        end
        return m;
    endfunction

endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && !clear_i && (cnt_q == LAST);

    // R9: a halted or disabled prescaler keeps its phase
    a_r9_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int LOCK_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              restart_ok_i,
    output mode_t             mode_o,
    output cnt_t              reload_nxt_o,
    output logic              mode_wr_o,
    output logic              restart_req_o
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    mode_t        mode_q;
    mode_t        merged;
    logic [LW-1:0] lock_q;
    logic         locked;
    logic         wr_ok;

    assign locked = (lock_q != '0);
    assign wr_ok  = wr_en_i && !locked;

    assign mode_wr_o     = wr_ok && (reg_addr_e'(wr_addr_i) == A_MODE);
    assign restart_req_o = wr_ok && (reg_addr_e'(wr_addr_i) == A_CTRL) && is_restart(wr_data_i);

    assign merged       = mode_merge(mode_q, mode_t'(wr_data_i));
    assign reload_nxt_o = mode_wr_o ? merged.reload : mode_q.reload;
    assign mode_o       = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_reset();
            lock_q <= '0;
        end else begin
            if (mode_wr_o) begin
                mode_q <= merged;
            end
            if (restart_ok_i) begin
                lock_q <= LW'(LOCK_CYC);
            end else if (locked) begin
                lock_q <= lock_q - 1'b1;
            end
        end
    end

    // R6: nothing reaches the mode word during the lock
    a_r6_lock_mode: assert property (@(posedge clk) disable iff (rst)
        locked |=> (mode_q == $past(mode_q)));

    // R7: load and window never change across a cycle that ends disabled
    a_r7_frozen_reload: assert property (@(posedge clk) disable iff (rst)
        mode_q.dis |=> (!mode_q.dis || (mode_q.reload == $past(mode_q.reload))));
    a_r7_frozen_window: assert property (@(posedge clk) disable iff (rst)
        mode_q.dis |=> (!mode_q.dis || (mode_q.window == $past(mode_q.window))));

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_i,
    input  logic    dis_i,
    input  cnt_t    window_i,
    input  cnt_t    reload_nxt_i,
    input  logic    mode_wr_i,
    input  logic    restart_req_i,
    input  logic    stat_clr_i,
    output cnt_t    cnt_o,
    output status_t status_o,
    output logic    restart_ok_o,
    output logic    load_o,
    output logic    fault_o
);
    cnt_t    cnt_q;
    status_t stat_q;
    logic    early;
    logic    win_err;
    logic    unf;

    assign early        = (cnt_q > window_i);
    assign restart_ok_o = restart_req_i && (dis_i || !early);
    assign win_err      = restart_req_i && !dis_i && early;
    assign load_o       = mode_wr_i || restart_ok_o;
    assign unf          = tick_i && !load_o && (cnt_q == '0);
    assign fault_o      = unf || win_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_MAX;
            stat_q <= '0;
        end else begin
            if (load_o) begin
                cnt_q <= reload_nxt_i;
            end else if (tick_i) begin
                cnt_q <= (cnt_q == '0) ? reload_nxt_i : cnt_q - 1'b1;
            end
            stat_q.underflow <= (stat_q.underflow && !stat_clr_i) || unf;
            stat_q.win_err   <= (stat_q.win_err && !stat_clr_i) || win_err;
        end
    end

    assign cnt_o    = cnt_q;
    assign status_o = stat_q;

    // R2: after an underflow the counter restarts from the load value
    a_r2_unf_reload: assert property (@(posedge clk) disable iff (rst)
        unf |=> (cnt_q == $past(reload_nxt_i)));

    // R10: a status read with no new event leaves it empty
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_clr_i && !fault_o) |=> (stat_q == '0));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int PRESC_DIV = 128,
    parameter int LOCK_CYC  = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        idle,
    input  logic        debug,
    output logic        reset_req,
    output logic        irq_req
);
    mode_t   mode;
    cnt_t    reload_nxt;
    cnt_t    cnt;
    status_t status;
    logic    mode_wr;
    logic    restart_req;
    logic    restart_ok;
    logic    load;
    logic    fault;
    logic    tick;
    logic    run;
    logic    stat_clr;
    logic    rst_req_q;

    assign run = !mode.dis
              && !(mode.idle_halt && idle)
              && !(mode.dbg_halt && debug);

    assign stat_clr = rd_en && (reg_addr_e'(rd_addr) == A_STAT);

    kwdt_regs #(.LOCK_CYC(LOCK_CYC)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .restart_ok_i  (restart_ok),
        .mode_o        (mode),
        .reload_nxt_o  (reload_nxt),
        .mode_wr_o     (mode_wr),
        .restart_req_o (restart_req)
    );

    kwdt_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .clear_i (load),
        .tick_o  (tick)
    );

    kwdt_core u_core (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick),
        .dis_i         (mode.dis),
        .window_i      (mode.window),
        .reload_nxt_i  (reload_nxt),
        .mode_wr_i     (mode_wr),
        .restart_req_i (restart_req),
        .stat_clr_i    (stat_clr),
        .cnt_o         (cnt),
        .status_o      (status),
        .restart_ok_o  (restart_ok),
        .load_o        (load),
        .fault_o       (fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= fault && mode.rst_en;
        end
    end

    assign reset_req = rst_req_q;
    assign irq_req   = mode.irq_en && (status.underflow || status.win_err);

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            A_MODE:  rd_data = mode;
            A_STAT:  rd_data = {{(DATA_W-STAT_W){1'b0}}, status};
            A_CNT:   rd_data = {{(DATA_W-CNT_W){1'b0}}, cnt};
            default: rd_data = '0;
        endcase
    end

    // R3: a reset request only follows a cycle with reset-enable set
    a_r3_rst_gated: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(mode.rst_en));

    // R5: a window error only appears after the counter sat above the window
    a_r5_err_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(status.win_err) |-> $past(cnt > mode.window));

    // R7: a disabled counter does not move unless it is loaded
    a_r7_stopped: assert property (@(posedge clk) disable iff (rst)
        (mode.dis && !load) |=> $stable(cnt));

    // R10: the interrupt stays up until status is read or the enable drops
    a_r10_irq_held: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !stat_clr) |=> (irq_req || !mode.irq_en));

endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        idle = 1'b0;
    logic        debug = 1'b0;
    logic        reset_req;
    logic        irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    keyed_wdt #(.PRESC_DIV(DIV), .LOCK_CYC(3)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .idle(idle),
        .debug(debug), .reset_req(reset_req), .irq_req(irq_req)
    );

    function automatic logic [31:0] mk(bit dis, int win, bit dh, bit ih, bit re, bit ie, int rel);
        logic [11:0] w = win[11:0];
        logic [11:0] r = rel[11:0];
        return {dis, 3'b000, w, dh, ih, re, ie, r};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        rd_addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [31:0] d);
        rd_addr = a; rd_en = 1'b0;
        #1 d = rd_data;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int n;
        bit seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(2'd1, v); chk("R1 mode", v, 32'h0FFF2FFF);
        peek(2'd3, v); chk("R1 counter", v, 32'hFFF);
        peek(2'd2, v); chk("R1 status", v, 32'h0);
        chk("R1 reset_req", {31'b0, reset_req}, 32'h0);
        chk("R1 irq_req", {31'b0, irq_req}, 32'h0);

        // R2/R3 underflow point and reset pulse, load values swept
        for (int r = 0; r <= 5; r++) begin
            wr(2'd1, mk(0, r, 0, 0, 1, 0, r));
            n = 0;
            while (!reset_req && n < 200) begin @(negedge clk); n++; end
            chk("R2 underflow clocks", n, DIV * (r + 1));
            peek(2'd3, v); chk("R2 reload after underflow", v, r);
            @(negedge clk);
            chk("R3 reset pulse width", {31'b0, reset_req}, 32'h0);
            rd(2'd2, v); chk("R3 status underflow", v, 32'h1);
            rd(2'd2, v); chk("R10 status cleared", v, 32'h0);
        end

        // R3/R10 interrupt flavour, swept
        for (int r = 0; r <= 3; r++) begin
            wr(2'd1, mk(0, r, 0, 0, 0, 1, r));
            rd(2'd2, v);
            n = 1; seen = 1'b0;
            while (!irq_req && n < 200) begin
                @(negedge clk); n++;
                if (reset_req) seen = 1'b1;
            end
            chk("R3 irq underflow clocks", n, DIV * (r + 1));
            chk("R3 no reset when disabled", {31'b0, seen}, 32'h0);
            rd(2'd2, v); chk("R10 status read", v, 32'h1);
            chk("R10 irq drops after read", {31'b0, irq_req}, 32'h0);
        end

        // R8 mode write loads the counter; R2 step rate
        wr(2'd1, mk(0, 40, 0, 0, 0, 0, 40));
        peek(2'd3, v); chk("R8 load on mode write", v, 40);
        wait_n(20);
        peek(2'd3, v); chk("R2 five ticks", v, 35);
        wr(2'd1, mk(0, 40, 0, 0, 0, 0, 40));
        peek(2'd3, v); chk("R8 reload on second write", v, 40);

        // R4 key
        wait_n(8);
        peek(2'd3, v); chk("R2 two ticks", v, 38);
        wr(2'd0, 32'h5A000001);
        peek(2'd3, v); chk("R4 wrong key ignored", v, 38);
        wr(2'd0, 32'hA5000000);
        peek(2'd3, v); chk("R4 no restart bit ignored", v, 38);
        wr(2'd0, 32'hA5000001);
        peek(2'd3, v); chk("R4 keyed restart", v, 40);

        // R6 lock window
        wr(2'd1, mk(0, 30, 0, 0, 0, 0, 30));
        wr(2'd1, mk(0, 30, 0, 0, 0, 0, 30));
        wr(2'd1, mk(0, 30, 0, 0, 0, 0, 30));
        peek(2'd1, v); chk("R6 writes locked", v & 32'hFFF, 40);
        wr(2'd1, mk(0, 30, 0, 0, 0, 0, 30));
        peek(2'd1, v); chk("R6 fourth write taken", v & 32'hFFF, 30);
        peek(2'd3, v); chk("R6 fourth write loads", v, 30);

        // R5 window
        wr(2'd1, mk(0, 5, 0, 0, 0, 1, 20));
        wait_n(8);
        wr(2'd0, 32'hA5000001);
        peek(2'd3, v); chk("R5 early restart keeps count", v, 18);
        chk("R5 early restart irq", {31'b0, irq_req}, 32'h1);
        rd(2'd2, v); chk("R5 window error status", v, 32'h2);
        n = 0;
        peek(2'd3, v);
        while (v > 5 && n < 200) begin @(negedge clk); n++; peek(2'd3, v); end
        wr(2'd0, 32'hA5000001);
        peek(2'd3, v); chk("R5 in-window restart", v, 20);
        peek(2'd2, v); chk("R5 no error in window", v, 32'h0);
        wait_n(4);
        wr(2'd1, mk(0, 5, 0, 0, 1, 0, 20));
        wr(2'd0, 32'hA5000001);
        chk("R5 error raises reset", {31'b0, reset_req}, 32'h1);
        @(negedge clk);
        rd(2'd2, v);

        // R7 disable freeze
        wr(2'd1, mk(1, 10, 0, 0, 1, 0, 10));
        peek(2'd3, v); chk("R7 disable write loads", v, 10);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (reset_req) seen = 1'b1; end
        peek(2'd3, v); chk("R7 counter frozen", v, 10);
        chk("R7 no underflow disabled", {31'b0, seen}, 32'h0);
        wr(2'd1, mk(1, 7, 0, 0, 1, 1, 7));
        peek(2'd1, v); chk("R7 fields frozen", v, mk(1, 10, 0, 0, 1, 1, 10));
        wr(2'd1, mk(0, 7, 0, 0, 1, 0, 7));
        peek(2'd1, v); chk("R7 fields change on enable", v, mk(0, 7, 0, 0, 1, 0, 7));

        // R9 halts
        wr(2'd1, mk(0, 50, 0, 1, 0, 0, 50));
        idle = 1'b1;
        wait_n(40);
        peek(2'd3, v); chk("R9 idle halt holds", v, 50);
        idle = 1'b0;
        wait_n(8);
        peek(2'd3, v); chk("R9 resumes after idle", v, 48);
        debug = 1'b1;
        wait_n(8);
        peek(2'd3, v); chk("R9 debug ignored without enable", v, 46);
        wr(2'd1, mk(0, 50, 1, 0, 0, 0, 50));
        wait_n(20);
        peek(2'd3, v); chk("R9 debug halt holds", v, 50);
        debug = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule